// File: doc/BRIEF.md
# Die-to-Die Mainband Training Sequencer

This block walks a die-to-die link from reset through its mainband initialization and training steps until the link is usable. At each step it talks to the partner die through an abstract sideband message port. An outgoing channel carries valid, ready and an 8-bit opcode. An incoming channel carries valid and an opcode. The block never moves on until the partner has answered.

The physical-layer actions are reduced to handshakes. These are a clock/track lane check that reports lanes one at a time, a PLL request with a lock indication, and per-step point tests and eye sweeps that run as sideband request/response pairs. A programmable no-progress timeout guards every wait.

The sequencer exposes its current step, an error flag with a cause code, and an active flag. A separate link-up output combines the active flag with the raw and flit interface states.

Top module: `mb_train_seq`

## Requirements
- R1: While rst_ni is low, and afterwards until start_i is seen, state_o is 0 (idle), and active_o, err_o, sb_tx_valid_o, pll_req_o and lane_chk_o are all 0. err_code_o reads 0 after reset.
- R2: After start_i, state_o visits every step in this order with none skipped: 1 lane check, 2 valid-lane vref, 3 data vref, 4 speed idle, 5 valid-lane centering, 6 data centering one, 7 receive deskew, 8 data centering two, 9 link speed, then 10 active. Code 15 is the error state.
- R3: In step 1, lane_chk_o is high and the lanes must be reported on lane_vld_i/lane_id_i in the order 0 (positive clock), 1 (negative clock), 2 (track), 3 (remaining clock). Any other id enters error with err_code_o = 2.
- R4: Opcodes carry a kind in bits 7:4 and the step code in bits 3:0. In steps 2 and 3 with pt_en_i high, a point-test request (kind 1) is sent, and the step waits for the response (kind 2, same step code). With pt_en_i low, no request is sent.
- R5: In step 4, pll_req_o stays high and the step does not advance until pll_lock_i is high.
- R6: In steps 5 to 8, each sweep step sends kind 3 and waits for kind 4 with the same step code. Step 5 runs STEPS exchanges. Steps 6, 7 and 8 each run STEPS times REPEATS exchanges.
- R7: Every step ends with an exit request (kind 5) and needs the exit response (kind 6) before the next step. A request holds valid and opcode stable until ready.
- R8: If no progress occurs for more than tmo_lim_i cycles during training, the block enters error with err_code_o = 1. No error occurs while progress continues.
- R9: A received opcode that does not match the awaited response enters error with err_code_o = 3.
- R10: The error state holds until reset. In error, sb_tx_valid_o, pll_req_o, lane_chk_o and active_o are 0, and start_i has no effect.
- R11: active_o rises only after the link speed step completes. link_up_o is high only when active_o, rdi_active_i and fdi_active_i are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin training from idle |
| pt_en_i | input | 1 | Enable point tests in the vref steps |
| tmo_lim_i | input | TMO_W | No-progress timeout limit in cycles |
| sb_tx_valid_o | output | 1 | Outgoing message valid |
| sb_tx_ready_i | input | 1 | Partner accepts outgoing message |
| sb_tx_op_o | output | 8 | Outgoing opcode {kind, step} |
| sb_rx_valid_i | input | 1 | Incoming message valid |
| sb_rx_op_i | input | 8 | Incoming opcode {kind, step} |
| pll_req_o | output | 1 | PLL reprogram request |
| pll_lock_i | input | 1 | PLL lock indication |
| lane_chk_o | output | 1 | Lane check in progress |
| lane_vld_i | input | 1 | Lane check report valid |
| lane_id_i | input | 2 | Lane id of the report |
| rdi_active_i | input | 1 | Raw interface state is active |
| fdi_active_i | input | 1 | Flit interface state is active |
| state_o | output | 4 | Current step code |
| err_o | output | 1 | Error state |
| err_code_o | output | 2 | Error cause: 1 timeout, 2 lane order, 3 bad message |
| active_o | output | 1 | Training complete |
| link_up_o | output | 1 | Data may flow |

## Verification
A request appears on sb_tx_op_o in the cycle after the step or phase register changes. A response presented during cycle n is taken at the edge that ends n, so the partner model answers one falling edge after each handshake. The PLL model asserts lock five cycles after the request, and a timeout error lands tmo_lim_i plus one cycles after the last progress.

A scoreboard compares every accepted outgoing opcode and every step change, at the falling edge, against queues built from the requirements. Window checks wait for the relevant step first and then sample well inside or well past the due cycle. link_up_o is combinational and is read one time unit after its inputs change.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  localparam int OP_W = 8;
  localparam int N_LANES = 4;

  typedef enum logic [3:0] {
    S_RESET = 4'd0, S_LANE = 4'd1, S_VVREF = 4'd2, S_DVREF = 4'd3,
    S_SPD = 4'd4, S_VCTR = 4'd5, S_DC1 = 4'd6, S_DSK = 4'd7,
    S_DC2 = 4'd8, S_LSPD = 4'd9, S_ACTIVE = 4'd10, S_ERR = 4'd15
  } sub_e;

  typedef enum logic [1:0] {PH_ACT, PH_ACT_W, PH_EXIT, PH_EXIT_W} ph_e;

  localparam logic [3:0] K_PT_REQ   = 4'd1;
  localparam logic [3:0] K_PT_RSP   = 4'd2;
  localparam logic [3:0] K_SWP_REQ  = 4'd3;
  localparam logic [3:0] K_SWP_RSP  = 4'd4;
  localparam logic [3:0] K_EXIT_REQ = 4'd5;
  localparam logic [3:0] K_EXIT_RSP = 4'd6;

  localparam logic [1:0] E_NONE = 2'd0;
  localparam logic [1:0] E_TMO  = 2'd1;
  localparam logic [1:0] E_LANE = 2'd2;
  localparam logic [1:0] E_MSG  = 2'd3;
endpackage

// File: rtl/mbt_lane_order.sv
module mbt_lane_order #(
  parameter int N = 4,
  localparam int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          vld_i,
  input  logic [LW-1:0] id_i,
  output logic          step_o,
  output logic          done_o,
  output logic          bad_o
);
  logic [LW-1:0] idx_q;

  assign step_o = en_i && vld_i && (id_i == idx_q);
  assign done_o = step_o && (idx_q == LW'(N-1));
  assign bad_o  = en_i && vld_i && (id_i != idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (!en_i)  idx_q <= '0;
    else if (step_o) idx_q <= idx_q + LW'(1);
  end

  // R3
  lane_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !vld_i) |=> (idx_q == $past(idx_q) || !$past(en_i)));
endmodule

// File: rtl/mbt_sweep_cnt.sv
module mbt_sweep_cnt #(
  parameter int STEPS = 16,
  parameter int REPEATS = 15,
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int RW = (REPEATS > 1) ? $clog2(REPEATS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic multi_i,
  output logic last_o
);
  logic [SW-1:0] step_q;
  logic [RW-1:0] rep_q;
  logic step_last;

  assign step_last = (step_q == SW'(STEPS-1));
  assign last_o = step_last && (!multi_i || rep_q == RW'(REPEATS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      rep_q  <= '0;
    end else if (clr_i) begin
      step_q <= '0;
      rep_q  <= '0;
    end else if (inc_i) begin
      if (step_last) begin
        step_q <= '0;
        rep_q  <= rep_q + RW'(1);
      end else begin
        step_q <= step_q + SW'(1);
      end
    end
  end

  // R6
  sweep_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && last_o && !clr_i) |=> (step_q == '0));
endmodule

// File: rtl/mbt_timeout.sv
module mbt_timeout #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || clr_i)   cnt_q <= '0;
    else if (cnt_q != '1)       cnt_q <= cnt_q + W'(1);
  end

  // R8
  tmo_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && !expired_o) |=> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/mb_train_seq.sv
module mb_train_seq
  import mbt_pkg::*;
#(
  parameter int STEPS = 16,
  parameter int REPEATS = 15,
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pt_en_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  output logic             sb_tx_valid_o,
  input  logic             sb_tx_ready_i,
  output logic [OP_W-1:0]  sb_tx_op_o,
  input  logic             sb_rx_valid_i,
  input  logic [OP_W-1:0]  sb_rx_op_i,
  output logic             pll_req_o,
  input  logic             pll_lock_i,
  output logic             lane_chk_o,
  input  logic             lane_vld_i,
  input  logic [1:0]       lane_id_i,
  input  logic             rdi_active_i,
  input  logic             fdi_active_i,
  output logic [3:0]       state_o,
  output logic             err_o,
  output logic [1:0]       err_code_o,
  output logic             active_o,
  output logic             link_up_o
);
  sub_e sub_q, sub_d;
  ph_e  ph_q, ph_d;
  logic [1:0] code_q, code_d;
  logic lane_en, lane_step, lane_done, lane_bad;
  logic sw_inc, sw_clr, sw_multi, sw_last;
  logic tmo_run, tmo_clr, tmo_exp;
  logic tx_vld, is_vref, is_sweep;
  logic [3:0] tx_kind, rsp_kind;

  assign is_vref  = (sub_q == S_VVREF) || (sub_q == S_DVREF);
  assign sw_multi = (sub_q == S_DC1) || (sub_q == S_DSK) || (sub_q == S_DC2);
  assign is_sweep = sw_multi || (sub_q == S_VCTR);
  assign tmo_run  = (sub_q != S_RESET) && (sub_q != S_ACTIVE) && (sub_q != S_ERR);
  assign rsp_kind = is_vref ? K_PT_RSP : K_SWP_RSP;

  mbt_lane_order #(.N(N_LANES)) u_lane (
    .clk_i, .rst_ni, .en_i(lane_en), .vld_i(lane_vld_i), .id_i(lane_id_i),
    .step_o(lane_step), .done_o(lane_done), .bad_o(lane_bad)
  );

  mbt_sweep_cnt #(.STEPS(STEPS), .REPEATS(REPEATS)) u_sweep (
    .clk_i, .rst_ni, .clr_i(sw_clr), .inc_i(sw_inc), .multi_i(sw_multi),
    .last_o(sw_last)
  );

  mbt_timeout #(.W(TMO_W)) u_tmo (
    .clk_i, .rst_ni, .run_i(tmo_run), .clr_i(tmo_clr), .lim_i(tmo_lim_i),
    .expired_o(tmo_exp)
  );

  always_comb begin
    sub_d     = sub_q;
    ph_d      = ph_q;
    code_d    = code_q;
    tx_vld    = 1'b0;
    tx_kind   = K_EXIT_REQ;
    pll_req_o = 1'b0;
    lane_en   = 1'b0;
    sw_inc    = 1'b0;
    if (sub_q == S_RESET) begin
      if (start_i) begin
        sub_d = S_LANE;
        ph_d  = PH_ACT;
      end
    end else if (tmo_run) begin
      case (ph_q)
        PH_ACT: begin
          if (sub_q == S_LANE) begin
            lane_en = 1'b1;
            if (lane_done) ph_d = PH_EXIT;
          end else if (is_vref) begin
            if (pt_en_i) begin
              tx_vld  = 1'b1;
              tx_kind = K_PT_REQ;
              if (sb_tx_ready_i) ph_d = PH_ACT_W;
            end else begin
              ph_d = PH_EXIT;
            end
          end else if (sub_q == S_SPD) begin
            pll_req_o = 1'b1;
            if (pll_lock_i) ph_d = PH_EXIT;
          end else if (is_sweep) begin
            tx_vld  = 1'b1;
            tx_kind = K_SWP_REQ;
            if (sb_tx_ready_i) ph_d = PH_ACT_W;
          end else begin
            ph_d = PH_EXIT;
          end
        end
        PH_ACT_W: begin
          if (sb_rx_valid_i) begin
            if (sb_rx_op_i == {rsp_kind, 4'(sub_q)}) begin
              if (is_vref) begin
                ph_d = PH_EXIT;
              end else begin
                sw_inc = 1'b1;
                ph_d   = sw_last ? PH_EXIT : PH_ACT;
              end
            end else begin
              sub_d  = S_ERR;
              code_d = E_MSG;
            end
          end
        end
        PH_EXIT: begin
          tx_vld = 1'b1;
          if (sb_tx_ready_i) ph_d = PH_EXIT_W;
        end
        default: begin
          if (sb_rx_valid_i) begin
            if (sb_rx_op_i == {K_EXIT_RSP, 4'(sub_q)}) begin
              sub_d = sub_e'(4'(sub_q) + 4'd1);
              ph_d  = PH_ACT;
            end else begin
              sub_d  = S_ERR;
              code_d = E_MSG;
            end
          end
        end
      endcase
      if (lane_bad) begin
        sub_d  = S_ERR;
        code_d = E_LANE;
      end
      if (tmo_exp) begin
        sub_d  = S_ERR;
        code_d = E_TMO;
      end
    end
  end

  assign sw_clr  = (sub_d != sub_q);
  assign tmo_clr = (sub_d != sub_q) || (ph_d != ph_q) || sw_inc || lane_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= S_RESET;
      ph_q   <= PH_ACT;
      code_q <= E_NONE;
    end else begin
      sub_q  <= sub_d;
      ph_q   <= ph_d;
      code_q <= code_d;
    end
  end

  assign sb_tx_valid_o = tx_vld;
  assign sb_tx_op_o    = {tx_kind, 4'(sub_q)};
  assign lane_chk_o    = lane_en;
  assign state_o       = 4'(sub_q);
  assign err_o         = (sub_q == S_ERR);
  assign err_code_o    = code_q;
  assign active_o      = (sub_q == S_ACTIVE);
  assign link_up_o     = active_o && rdi_active_i && fdi_active_i;

  // R2
  state_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_q != $past(sub_q)) |-> ((4'(sub_q) == 4'($past(sub_q)) + 4'd1) || sub_q == S_ERR));

  // R10
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_q == S_ERR) |=> (sub_q == S_ERR));

  // R5
  pll_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_q == S_SPD && ph_q == PH_ACT && !pll_lock_i && !tmo_exp) |=> (sub_q == S_SPD && ph_q == PH_ACT));

  // R7
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sb_tx_valid_o && !sb_tx_ready_i && !tmo_exp) |=> (sb_tx_valid_o && $stable(sb_tx_op_o)));

  // R11
  active_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> ($past(sub_q) == S_LSPD));
endmodule

// File: tb/sim_mb_train_seq.sv
module sim_mb_train_seq;
  localparam int STEPS = 16;
  localparam int REPS = 15;
  localparam int TW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni, start, pt_en, tx_valid, tx_ready, rx_valid, pll_req, pll_lock;
  logic lane_chk, lane_vld, rdi, fdi, err, active, link_up;
  logic [TW-1:0] lim;
  logic [7:0] tx_op, rx_op;
  logic [1:0] lane_id, err_code;
  logic [3:0] state;

  mb_train_seq #(.STEPS(STEPS), .REPEATS(REPS), .TMO_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .pt_en_i(pt_en), .tmo_lim_i(lim),
    .sb_tx_valid_o(tx_valid), .sb_tx_ready_i(tx_ready), .sb_tx_op_o(tx_op),
    .sb_rx_valid_i(rx_valid), .sb_rx_op_i(rx_op), .pll_req_o(pll_req), .pll_lock_i(pll_lock),
    .lane_chk_o(lane_chk), .lane_vld_i(lane_vld), .lane_id_i(lane_id),
    .rdi_active_i(rdi), .fdi_active_i(fdi), .state_o(state), .err_o(err),
    .err_code_o(err_code), .active_o(active), .link_up_o(link_up)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [7:0] exp_q[$];
  logic [3:0] st_q[$];
  bit sb_on = 0, lock_ok = 1, ready_mode = 0;
  logic [3:0] stall_sub = 4'd0, corrupt_sub = 4'd0;
  int lane_ord[4] = '{0, 1, 2, 3};
  int lane_idx = 0, pll_cnt = 0;
  bit pend = 0;
  logic [7:0] pend_op;
  logic [3:0] last_st = 4'd0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic string kind_req(input logic [3:0] k);
    if (k == 4'd1) return "R4 point-test op";
    if (k == 4'd3) return "R6 sweep op";
    return "R7 exit op";
  endfunction

  // partner, PLL, lane models and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    tx_ready = ready_mode ? ((cyc % 2) == 0) : 1'b1;
    if (!rst_ni) begin
      pend = 0; rx_valid = 0; rx_op = '0; lane_idx = 0; lane_vld = 0; lane_id = '0;
      pll_cnt = 0; pll_lock = 0; last_st = 4'd0;
    end else begin
      rx_valid = 0;
      if (pend) begin
        rx_valid = 1;
        rx_op = pend_op;
        pend = 0;
      end
      if (tx_valid && tx_ready) begin
        if (sb_on) begin
          if (exp_q.size() == 0) check(0, kind_req(tx_op[7:4]), tx_op, -1);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(tx_op == e, kind_req(e[7:4]), tx_op, e);
          end
        end
        if (tx_op[3:0] != stall_sub) begin
          pend = 1;
          pend_op = (tx_op[3:0] == corrupt_sub) ? {tx_op[7:4] + 4'd1, tx_op[3:0] + 4'd1}
                                                : {tx_op[7:4] + 4'd1, tx_op[3:0]};
        end
      end
      if (state != last_st) begin
        if (sb_on) begin
          if (st_q.size() == 0) check(0, "R2 state order", state, -1);
          else begin
            logic [3:0] es;
            es = st_q.pop_front();
            check(state == es, "R2 state order", state, es);
          end
        end
        last_st = state;
      end
      if (pll_req) pll_cnt++; else pll_cnt = 0;
      pll_lock = lock_ok && (pll_cnt >= 5);
      lane_vld = 0;
      if (lane_chk && lane_idx < 4) begin
        lane_vld = 1;
        lane_id = 2'(lane_ord[lane_idx]);
        lane_idx++;
      end
    end
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic do_reset();
    rst_ni = 0; start = 0; sb_on = 0;
    exp_q.delete(); st_q.delete();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_state(input logic [3:0] v, input int cap);
    int n = 0;
    while (state != v && state != 4'd15 && n < cap) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic push_expect(input bit pt);
    for (int s = 1; s <= 9; s++) begin
      if ((s == 2 || s == 3) && pt) exp_q.push_back({4'd1, 4'(s)});
      if (s == 5) for (int i = 0; i < STEPS; i++) exp_q.push_back({4'd3, 4'(s)});
      if (s >= 6 && s <= 8) for (int i = 0; i < STEPS * REPS; i++) exp_q.push_back({4'd3, 4'(s)});
      exp_q.push_back({4'd5, 4'(s)});
      st_q.push_back(4'(s));
    end
    st_q.push_back(4'd10);
  endtask

  task automatic full_run(input bit pt);
    pt_en = pt;
    push_expect(pt);
    sb_on = 1;
    pulse_start();
    wait_state(4'd10, 40000);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R6/R7 all requests sent", exp_q.size(), 0);
    check(st_q.size() == 0, "R2 all states visited", st_q.size(), 0);
    check(state == 4'd10, "R2 reached active", state, 10);
    check(active == 1'b1 && err == 1'b0, "R11 active flag", active, 1);
    sb_on = 0;
  endtask

  initial begin
    rst_ni = 0; start = 0; pt_en = 1; lim = TW'(40); rdi = 0; fdi = 0;
    tx_ready = 1; rx_valid = 0; rx_op = '0; pll_lock = 0; lane_vld = 0; lane_id = '0;
    repeat (2) @(negedge clk);
    check(state == 4'd0 && active == 0 && err == 0, "R1 reset state", state, 0);
    check(tx_valid == 0 && pll_req == 0 && lane_chk == 0, "R1 outputs idle", tx_valid, 0);
    do_reset();
    repeat (10) @(negedge clk);
    check(state == 4'd0 && err_code == 2'd0, "R1 idle without start", state, 0);

    // full training, point tests enabled, ready always high
    full_run(1'b1);
    for (int c = 0; c < 4; c++) begin
      rdi = c[0]; fdi = c[1];
      #1;
      check(link_up == (c == 3), "R11 link up gating", link_up, c == 3);
      @(negedge clk);
    end
    rdi = 0; fdi = 0;

    // full training, point tests disabled, ready toggling
    do_reset();
    ready_mode = 1;
    full_run(1'b0);
    ready_mode = 0;

    // PLL lock withheld
    do_reset();
    pt_en = 1; lock_ok = 0;
    pulse_start();
    wait_state(4'd4, 2000);
    repeat (30) @(negedge clk);
    check(state == 4'd4, "R5 holds without lock", state, 4);
    check(pll_req == 1'b1 && tx_valid == 1'b0, "R5 pll request held", pll_req, 1);
    lock_ok = 1;
    wait_state(4'd5, 200);
    check(state == 4'd5, "R5 advances after lock", state, 5);

    // timeout while partner stays silent in step 2
    do_reset();
    stall_sub = 4'd2;
    pulse_start();
    wait_state(4'd2, 2000);
    repeat (20) @(negedge clk);
    check(err == 1'b0 && state == 4'd2, "R8 no early timeout", state, 2);
    repeat (50) @(negedge clk);
    check(state == 4'd15 && err_code == 2'd1, "R8 timeout error", err_code, 1);
    stall_sub = 4'd0;

    // mismatched response in step 3
    do_reset();
    corrupt_sub = 4'd3;
    pulse_start();
    wait_state(4'd15, 2000);
    check(state == 4'd15 && err_code == 2'd3, "R9 bad message error", err_code, 3);
    corrupt_sub = 4'd0;

    // wrong lane order
    do_reset();
    lane_ord = '{0, 2, 1, 3};
    pulse_start();
    wait_state(4'd15, 200);
    check(state == 4'd15 && err_code == 2'd2, "R3 lane order error", err_code, 2);
    repeat (30) @(negedge clk);
    pulse_start();
    repeat (5) @(negedge clk);
    check(state == 4'd15, "R10 error holds", state, 15);
    check(tx_valid == 0 && pll_req == 0 && lane_chk == 0 && active == 0,
          "R10 outputs quiet in error", tx_valid, 0);
    lane_ord = '{0, 1, 2, 3};
    do_reset();
    check(state == 4'd0 && err == 0 && err_code == 2'd0, "R1 reset clears error", state, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule